// File: doc/BRIEF.md
# QoS Buffer State Overwriter

This block sits in the transmit path of a wireless MAC. For each outgoing frame it gets the 16-bit frame control word, the 16-bit QoS control word and a few control bits that come with the frame. When the frame really carries a QoS control field and rewriting is enabled for that frame, the block replaces the upper byte of the QoS control word with a buffer-status byte taken from a local register file. Every other frame, and every disabled frame, leaves the block unchanged.

The register file holds one bank per station. The default is two banks. Each bank has one buffer-state byte per TID and one sum byte. A single-cycle write strobe loads any of these bytes. Two bits that come with each frame choose the byte to insert:

- a station-select bit picks the bank;
- a source-mode bit picks either the TID entry indexed by the frame's own TID, or the bank's sum byte.

The result is registered, so it appears one cycle after the frame is presented.

Top module: `qos_bufstate_ovr`

## Requirements
- R1: After reset, `out_valid` and `out_qos` are 0, and every stored buffer-state byte (per-TID and sum, in every bank) reads as 0x00.
- R2: A frame counts as carrying QoS only when frame control bits 3:2 equal 2'b10 (data type) and frame control bit 7 (upper subtype bit) is 1.
- R3: A frame presented with `in_ovr_en` = 0 leaves `out_qos` equal to `in_qos`.
- R4: A frame that does not carry QoS (see R2) leaves `out_qos` equal to `in_qos`, whatever the value of `in_ovr_en`.
- R5: Bits 7:0 of `out_qos` always equal bits 7:0 of the presented `in_qos`. This covers the TID in bits 3:0 and the ack policy in bits 6:5 (0 normal, 1 none, 2 PSMP, 3 block).
- R6: For a rewritten frame, `in_sta` = 0 takes the byte from bank 0 and `in_sta` = 1 takes it from bank 1.
- R7: With `in_src_sum` = 0, a rewritten frame gets the per-TID byte indexed by `in_qos[3:0]` in bits 15:8 of `out_qos`.
- R8: With `in_src_sum` = 1, a rewritten frame gets the selected bank's sum byte in bits 15:8 of `out_qos`.
- R9: A write with `wr_en` = 1 stores `wr_data` in bank `wr_sta`. Address 0 to 15 selects that TID's entry and address 16 selects the sum byte. Addresses 17 to 31 change nothing.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_qos` keeps its value while no frame is presented.
- R11: When a write and a lookup of the same entry happen in the same cycle, the lookup returns the value from before the write. The new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_sta | input | 1 | Bank to write |
| wr_addr | input | 5 | Entry to write: 0-15 TID, 16 sum |
| wr_data | input | 8 | Byte to store |
| in_valid | input | 1 | A frame is presented this cycle |
| in_fc | input | 16 | Frame control word |
| in_qos | input | 16 | QoS control word |
| in_ovr_en | input | 1 | Rewrite enable for this frame |
| in_sta | input | 1 | Bank used for this frame |
| in_src_sum | input | 1 | 0: per-TID byte, 1: sum byte |
| out_valid | output | 1 | Result valid |
| out_qos | output | 16 | QoS control word, possibly rewritten |

## Verification
The checker tests on every cycle the properties that do not need the register contents:

- the one-cycle valid timing and the hold of `out_qos` between frames;
- that the low byte is preserved;
- that disabled or non-QoS frames pass through unchanged;
- that the internal rewrite event only fires for valid, enabled QoS frames.

Which byte gets inserted depends on the history of writes. Only the bench's scenarios, which keep their own model of the register banks, can show that:

- bank and source selection are correct;
- out-of-range addresses are ignored;
- a lookup in the same cycle as a write returns the old value.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
  localparam int unsigned QW = 16;

  // frame carries a QoS control field: data type and upper subtype bit set
  function automatic logic qbs_is_qos(input logic [QW-1:0] fc);
    return (fc[3:2] == 2'b10) && fc[7];
  endfunction

  // keep the low byte of the QoS word, place the status byte above it
  function automatic logic [QW-1:0] qbs_merge(input logic [QW-1:0] qos,
                                              input logic [7:0]    status);
    return {status, qos[7:0]};
  endfunction
endpackage

// File: rtl/qbs_bank.sv
module qbs_bank #(
  parameter int unsigned NUM_TID = 16,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned TID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [TID_W-1:0]  rd_tid,
  input  logic              rd_sum,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [BYTE_W-1:0] tid_q [NUM_TID];
  logic [BYTE_W-1:0] sum_q;

  for (genvar t = 0; t < NUM_TID; t++) begin : g_tid
    always_ff @(posedge clk) begin
      if (!rst_n)                                   tid_q[t] <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(t)))    tid_q[t] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                     sum_q <= '0;
    else if (wr_en && (wr_addr == ADDR_W'(NUM_TID))) sum_q <= wr_data;
  end

  assign rd_byte = rd_sum ? sum_q : tid_q[rd_tid];
endmodule

// File: rtl/qbs_pick.sv
module qbs_pick #(
  parameter int unsigned NUM_STA = 2,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned STA_W   = 1
) (
  input  logic [NUM_STA-1:0][BYTE_W-1:0] bank_bytes,
  input  logic [STA_W-1:0]               sel,
  output logic [BYTE_W-1:0]              picked
);
  always_comb begin
    picked = '0;
    for (int b = 0; b < NUM_STA; b++)
      if (sel == STA_W'(b)) picked = bank_bytes[b];
  end
endmodule

// File: rtl/qos_bufstate_ovr.sv
module qos_bufstate_ovr #(
  parameter int unsigned NUM_STA = 2,
  parameter int unsigned NUM_TID = 16,
  parameter int unsigned BYTE_W  = 8,
  localparam int unsigned STA_W  = (NUM_STA > 1) ? $clog2(NUM_STA) : 1,
  localparam int unsigned ADDR_W = $clog2(NUM_TID + 1),
  localparam int unsigned TID_W  = $clog2(NUM_TID)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STA_W-1:0]  wr_sta,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              in_valid,
  input  logic [15:0]       in_fc,
  input  logic [15:0]       in_qos,
  input  logic              in_ovr_en,
  input  logic [STA_W-1:0]  in_sta,
  input  logic              in_src_sum,
  output logic              out_valid,
  output logic [15:0]       out_qos
);
  import qbs_pkg::*;

  logic [NUM_STA-1:0][BYTE_W-1:0] bank_bytes;
  logic [BYTE_W-1:0]              status_byte;
  logic                           rewrite_hit;
  logic [15:0]                    qos_next;

  for (genvar b = 0; b < NUM_STA; b++) begin : g_bank
    logic bank_we;
    assign bank_we = wr_en && (wr_sta == STA_W'(b));
    qbs_bank #(
      .NUM_TID(NUM_TID), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TID_W(TID_W)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_we),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_tid (in_qos[TID_W-1:0]),
      .rd_sum (in_src_sum),
      .rd_byte(bank_bytes[b])
    );
  end

  qbs_pick #(.NUM_STA(NUM_STA), .BYTE_W(BYTE_W), .STA_W(STA_W)) u_pick (
    .bank_bytes(bank_bytes),
    .sel       (in_sta),
    .picked    (status_byte)
  );

  assign rewrite_hit = in_valid && in_ovr_en && qbs_is_qos(in_fc);
  assign qos_next    = rewrite_hit ? qbs_merge(in_qos, status_byte) : in_qos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_qos   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_qos <= qos_next;
    end
  end
endmodule

// File: rtl/qbs_chk.sv
module qbs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_fc,
  input logic [15:0] in_qos,
  input logic        in_ovr_en,
  input logic        out_valid,
  input logic [15:0] out_qos,
  input logic        rewrite_hit
);
  a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_qos));
  a_r5_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_qos[7:0] == $past(in_qos[7:0])));
  a_r3_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ovr_en) |=> (out_qos == $past(in_qos)));
  a_r4_nonqos_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(in_fc[3] && !in_fc[2] && in_fc[7])) |=> (out_qos == $past(in_qos)));
  a_r2_hit_only_qos: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_hit |-> (in_valid && in_ovr_en && in_fc[7] && in_fc[3] && !in_fc[2]));
endmodule

bind qos_bufstate_ovr qbs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_fc      (in_fc),
  .in_qos     (in_qos),
  .in_ovr_en  (in_ovr_en),
  .out_valid  (out_valid),
  .out_qos    (out_qos),
  .rewrite_hit(rewrite_hit)
);

// File: tb/qos_bufstate_ovr_tb.sv
module qos_bufstate_ovr_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_sta = 0;
  logic [4:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic in_valid = 0, in_ovr_en = 0, in_sta = 0, in_src_sum = 0;
  logic [15:0] in_fc = 0, in_qos = 0;
  logic out_valid;
  logic [15:0] out_qos;
  int checks = 0, errors = 0;

  logic [7:0] m_tid [2][16];
  logic [7:0] m_sum [2];

  always #2 clk = ~clk;

  qos_bufstate_ovr u_dut (.*);

  localparam logic [15:0] FC_QOS  = 16'h0088;
  localparam logic [15:0] FC_DATA = 16'h0008;
  localparam logic [15:0] FC_MGMT = 16'h0080;
  localparam logic [15:0] FC_CTRL = 16'h0084;

  function automatic logic [15:0] model(logic [15:0] fc, logic [15:0] q,
                                        logic en, logic sta, logic src);
    logic [7:0] b;
    if (!(en && fc[7] && fc[3:2] == 2'b10)) return q;
    b = src ? m_sum[sta] : m_tid[sta][q[3:0]];
    return (q & 16'h00FF) | (16'(b) << 8);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sta, logic [4:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_sta = sta; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
    if (a < 16) m_tid[sta][a[3:0]] = d;
    else if (a == 16) m_sum[sta] = d;
  endtask

  task automatic frame(string req, logic [15:0] fc, logic [15:0] q,
                       logic en, logic sta, logic src);
    logic [15:0] e;
    @(negedge clk);
    e = model(fc, q, en, sta, src);
    in_valid = 1; in_fc = fc; in_qos = q; in_ovr_en = en; in_sta = sta; in_src_sum = src;
    @(posedge clk); #1;
    in_valid = 0;
    chk({req, " valid"}, {15'd0, out_valid}, 16'd1);
    chk(req, out_qos, e);
  endtask

  task automatic t_reset;
    chk("R1 valid", {15'd0, out_valid}, 16'd0);
    chk("R1 qos", out_qos, 16'd0);
    frame("R1 tid reg", FC_QOS, 16'hFF03, 1, 0, 0);
    frame("R1 sum reg", FC_QOS, 16'hFF03, 1, 1, 1);
  endtask

  task automatic t_fill;
    for (int t = 0; t < 16; t++) begin
      wr(0, 5'(t), 8'h10 + 8'(t));
      wr(1, 5'(t), 8'hA0 + 8'(t));
    end
    wr(0, 16, 8'h5C);
    wr(1, 16, 8'hC5);
  endtask

  task automatic t_tid_lookup;
    for (int t = 0; t < 16; t += 5) begin
      frame("R7 R6 bank0", FC_QOS, 16'h0000 | 16'(t), 1, 0, 0);
      frame("R7 R6 bank1", FC_QOS, 16'h3300 | 16'(t), 1, 1, 0);
    end
    frame("R2 subtype variant", 16'h00F8, 16'h000F, 1, 1, 0);
  endtask

  task automatic t_sum;
    frame("R8 bank0 sum", FC_QOS, 16'h0007, 1, 0, 1);
    frame("R8 bank1 sum", FC_QOS, 16'h0007, 1, 1, 1);
  endtask

  task automatic t_disabled;
    frame("R3 disabled", FC_QOS, 16'hBEEF, 0, 1, 0);
    frame("R3 disabled sum", FC_QOS, 16'h1234, 0, 0, 1);
  endtask

  task automatic t_nonqos;
    frame("R4 data no qos", FC_DATA, 16'h7702, 1, 0, 0);
    frame("R4 mgmt", FC_MGMT, 16'h6604, 1, 1, 1);
    frame("R4 ctrl", FC_CTRL, 16'h5509, 1, 0, 1);
  endtask

  task automatic t_low_byte;
    for (int ap = 0; ap < 4; ap++)
      frame("R5 ack policy", FC_QOS, 16'hAA00 | 16'(ap << 5) | 16'h0093, 1, ap[0], 0);
  endtask

  task automatic t_bad_addr;
    wr(0, 17, 8'hEE);
    wr(1, 31, 8'hDD);
    for (int t = 0; t < 16; t++) frame("R9 unchanged tid", FC_QOS, 16'(t), 1, 0, 0);
    frame("R9 unchanged sum", FC_QOS, 16'h0000, 1, 1, 1);
    wr(1, 3, 8'h42);
    frame("R9 new write", FC_QOS, 16'h0003, 1, 1, 0);
    frame("R9 other bank intact", FC_QOS, 16'h0003, 1, 0, 0);
  endtask

  task automatic t_rbw;
    logic [15:0] e;
    @(negedge clk);
    e = model(FC_QOS, 16'h0009, 1, 0, 0);
    wr_en = 1; wr_sta = 0; wr_addr = 9; wr_data = 8'h99;
    in_valid = 1; in_fc = FC_QOS; in_qos = 16'h0009; in_ovr_en = 1; in_sta = 0; in_src_sum = 0;
    @(posedge clk); #1;
    wr_en = 0; in_valid = 0;
    m_tid[0][9] = 8'h99;
    chk("R11 old value", out_qos, e);
    frame("R11 new value", FC_QOS, 16'h0009, 1, 0, 0);
  endtask

  task automatic t_hold;
    logic [15:0] prev;
    frame("R10 frame", FC_QOS, 16'h0001, 1, 1, 0);
    prev = out_qos;
    @(negedge clk);
    in_qos = 16'hFFFF; in_ovr_en = 1;
    @(posedge clk); #1;
    chk("R10 idle valid", {15'd0, out_valid}, 16'd0);
    chk("R10 hold", out_qos, prev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_sum[s] = 0;
      for (int t = 0; t < 16; t++) m_tid[s][t] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_fill;
    t_tid_lookup;
    t_sum;
    t_disabled;
    t_nonqos;
    t_low_byte;
    t_bad_addr;
    t_rbw;
    t_hold;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule